// File: doc/BRIEF.md
# Packed SIMD Multimedia ALU

This block is a 64-bit arithmetic unit that views each operand as a row of independent lanes. The lanes are eight bytes, four halfwords or two words. One opcode selects the operation for all lanes at once. A lane-size code picks the partitioning, and a signedness bit decides how lane values are read wherever that matters: for saturation, for the greater-than compare, for the multiply-accumulate widening and for narrowing.

The operations fall into five groups:
- **Add and subtract:** wrap within the lane, or clamp to the lane's limits.
- **Bitwise logic:** AND, OR, XOR and AND-with-complement.
- **Shifts:** logical left, logical right and arithmetic right, with one shared count taken from operand B.
- **Compares:** the result is mask-style, so each lane is all ones when the test holds and all zeros when it does not.
- **Halfword multiply, multiply-accumulate, and pack:** the multiply and multiply-accumulate work on halfword lanes. Pack halves the lane width with saturation.

Operands and controls are captured together at a clock edge, and the result appears one cycle later from a register. There is no handshake, and a new operation may be issued every cycle.

Top module: `simd_alu`

## Requirements
- R1: While `rst_n` is low the result register holds zero. Otherwise, the result of the operands and controls sampled at one rising edge is visible on `result` after that edge and holds until the next one.
- R2: `lane_sz` selects 8-bit lanes (0), 16-bit lanes (1) or 32-bit lanes (2 or 3). Opcode 0 adds and opcode 2 subtracts (A minus B) lane by lane, modulo the lane width. No carry or borrow passes from one lane into the next.
- R3: Opcode 1 (saturating add) and opcode 3 (saturating subtract) with `is_signed`=1 clamp a lane whose true result leaves the signed range of the lane. The clamp value is the largest positive value or the most negative value of that range.
- R4: The same opcodes with `is_signed`=0 clamp an unsigned lane. An add that overflows gives all ones, and a subtract that would go below zero gives zero.
- R5: Opcodes 4, 5, 6 and 7 give A AND B, (NOT A) AND B, A OR B and A XOR B over all 64 bits, for any `lane_sz`.
- R6: Opcodes 8, 9 and 10 shift every lane of A left logically, right logically, or right arithmetically. The shift count is the unsigned value of B[7:0] and is the same for every lane.
- R7: When the shift count is equal to or greater than the lane width, a logical shift gives a zero lane. An arithmetic shift fills the lane with its sign bit.
- R8: Opcode 11 sets each lane to all ones when the A and B lanes are equal, and to all zeros otherwise.
- R9: Opcode 12 sets each lane to all ones when the A lane is greater than the B lane, and to all zeros otherwise. The comparison is two's complement when `is_signed`=1 and unsigned when `is_signed`=0.
- R10: Opcode 13 multiplies four 16-bit lanes and keeps the low 16 bits of each product. `lane_sz` has no effect on it.
- R11: Opcode 14 forms four 16-bit products, signed when `is_signed`=1 and unsigned otherwise. It adds products 0 and 1 into result bits 31:0 and products 2 and 3 into bits 63:32, each sum taken modulo 2^32. `lane_sz` has no effect on it.
- R12: Opcode 15 narrows lanes. With `lane_sz`=1, 16-bit source lanes become bytes. With `lane_sz` 2 or 3, 32-bit source lanes become halfwords. Narrowed lanes from A fill result bits 31:0 and those from B fill bits 63:32, lowest lane first. A value that does not fit saturates. With `is_signed`=1 the source is two's complement and the target range is signed. With `is_signed`=0 the source and target are both unsigned. With `lane_sz`=0 the result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset of the result register |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand; bits 7:0 also give the shift count |
| opcode | input | 4 | Operation code, 0 to 15 as listed in the requirements |
| lane_sz | input | 2 | Lane partitioning: 0 byte, 1 halfword, 2 or 3 word |
| is_signed | input | 1 | Selects two's complement interpretation of lanes |
| result | output | 64 | Registered result |

## Verification
The hardest condition to reach is a lane that overflows while its neighbour does not. The carry kill at a lane boundary and the per-lane clamp only show up when adjacent lanes disagree. Uniform random operands seldom produce overflow in exactly one lane at the limit values.

The stimulus therefore draws operands from a pool of limit patterns, such as all ones, the sign-bit pattern and its complement, and mixes them with random words. Directed cases place values like 0xFF plus 0x01 into every byte and then reread the same bits at the wider lane sizes. Shift counts are biased toward the range around the lane widths, so that counts just below, at and above each width all occur.

// File: rtl/simd_pkg.sv
package simd_pkg;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_ADDS  = 4'd1,
        OP_SUB   = 4'd2,
        OP_SUBS  = 4'd3,
        OP_AND   = 4'd4,
        OP_ANDN  = 4'd5,
        OP_OR    = 4'd6,
        OP_XOR   = 4'd7,
        OP_SLL   = 4'd8,
        OP_SRL   = 4'd9,
        OP_SRA   = 4'd10,
        OP_CMPEQ = 4'd11,
        OP_CMPGT = 4'd12,
        OP_MUL   = 4'd13,
        OP_MADD  = 4'd14,
        OP_PACK  = 4'd15
    } simd_op_e;

    localparam int unsigned NUM_SIZES = 3;

endpackage

// File: rtl/simd_addsub.sv
// Byte-sliced adder whose carry chain is cut at lane starts chosen by lane_sz;
// per-lane saturation is decided at each lane's top byte and broadcast.
module simd_addsub #(
    parameter int unsigned DW = 64
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          sub,
    input  logic          sat,
    input  logic          sgn,
    input  logic [1:0]    sz,
    output logic [DW-1:0] y
);
    localparam int unsigned NB = DW / 8;

    logic [NB:0]   cout;
    logic [NB-1:0] ovf_s_v;
    logic [NB-1:0] ovf_u_v;
    logic [NB-1:0] neg_v;
    logic [DW-1:0] raw;

    assign cout[0] = 1'b0;

    for (genvar i = 0; i < NB; i++) begin : g_byte
        localparam bit H_START = (i % 2) == 0;
        localparam bit W_START = (i % 4) == 0;
        localparam int unsigned T16 = i | 1;
        localparam int unsigned T32 = i | 3;

        logic       start;
        logic       cin;
        logic [7:0] bb;
        logic [7:0] s;
        logic       c7;

        assign start = (sz == 2'd0) || (sz == 2'd1 && H_START) || (sz[1] && W_START);
        assign bb    = sub ? ~b[i*8 +: 8] : b[i*8 +: 8];
        assign cin   = start ? sub : cout[i];
        assign {cout[i+1], s} = {1'b0, a[i*8 +: 8]} + {1'b0, bb} + {8'd0, cin};
        assign c7    = a[i*8+7] ^ bb[7] ^ s[7];
        assign raw[i*8 +: 8] = s;
        assign ovf_s_v[i] = c7 ^ cout[i+1];
        assign ovf_u_v[i] = sub ? ~cout[i+1] : cout[i+1];
        assign neg_v[i]   = a[i*8+7];

        always_comb begin
            int unsigned top;
            logic        o_s;
            logic        o_u;
            logic        ng;
            top = sz[1] ? T32 : (sz[0] ? T16 : i);
            o_s = ovf_s_v[top];
            o_u = ovf_u_v[top];
            ng  = neg_v[top];
            y[i*8 +: 8] = raw[i*8 +: 8];
            if (sat && sgn && o_s) begin
                if (top == i) y[i*8 +: 8] = ng ? 8'h80 : 8'h7F;
                else          y[i*8 +: 8] = ng ? 8'h00 : 8'hFF;
            end else if (sat && !sgn && o_u) begin
                y[i*8 +: 8] = sub ? 8'h00 : 8'hFF;
            end
        end
    end
endmodule

// File: rtl/simd_lanewise.sv
// Shifts and mask compares, one copy per lane width, selected by lane_sz.
module simd_lanewise
    import simd_pkg::*;
#(
    parameter int unsigned DW = 64
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  simd_op_e      op,
    input  logic          sgn,
    input  logic [1:0]    sz,
    output logic [DW-1:0] sh_y,
    output logic [DW-1:0] cmp_y
);
    logic [NUM_SIZES-1:0][DW-1:0] sh_all;
    logic [NUM_SIZES-1:0][DW-1:0] cm_all;
    logic [7:0] cnt;

    assign cnt = b[7:0];

    for (genvar k = 0; k < NUM_SIZES; k++) begin : g_sz
        localparam int W = 8 << k;
        localparam int L = DW / W;
        for (genvar j = 0; j < L; j++) begin : g_lane
            logic [W-1:0] x;
            logic [W-1:0] z;
            logic [W-1:0] sh;
            logic [W-1:0] cm;
            assign x = a[j*W +: W];
            assign z = b[j*W +: W];
            always_comb begin
                if (int'(cnt) >= W) begin
                    sh = (op == OP_SRA && x[W-1]) ? '1 : '0;
                end else begin
                    case (op)
                        OP_SLL:  sh = x << cnt;
                        OP_SRL:  sh = x >> cnt;
                        default: sh = W'($signed(x) >>> cnt);
                    endcase
                end
                if (op == OP_CMPEQ) cm = (x == z) ? '1 : '0;
                else cm = (sgn ? ($signed(x) > $signed(z)) : (x > z)) ? '1 : '0;
            end
            assign sh_all[k][j*W +: W] = sh;
            assign cm_all[k][j*W +: W] = cm;
        end
    end

    assign sh_y  = sz[1] ? sh_all[2] : (sz[0] ? sh_all[1] : sh_all[0]);
    assign cmp_y = sz[1] ? cm_all[2] : (sz[0] ? cm_all[1] : cm_all[0]);
endmodule

// File: rtl/simd_mul.sv
// Halfword multiplier array; low halves form the plain product, pair sums the accumulate form.
module simd_mul #(
    parameter int unsigned DW = 64
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          sgn,
    output logic [DW-1:0] mul_y,
    output logic [DW-1:0] madd_y
);
    localparam int unsigned NH = DW / 16;
    localparam int unsigned NP = NH / 2;

    logic [31:0] prod [NH];

    for (genvar j = 0; j < NH; j++) begin : g_prod
        logic signed [16:0] xa;
        logic signed [16:0] xb;
        assign xa = {sgn & a[j*16+15], a[j*16 +: 16]};
        assign xb = {sgn & b[j*16+15], b[j*16 +: 16]};
        assign prod[j] = xa * xb;
        assign mul_y[j*16 +: 16] = prod[j][15:0];
    end

    for (genvar p = 0; p < NP; p++) begin : g_pair
        assign madd_y[p*32 +: 32] = prod[2*p] + prod[2*p+1];
    end
endmodule

// File: rtl/simd_pack.sv
// Saturating narrowing: A's narrowed lanes fill the low half, B's the high half.
module simd_pack #(
    parameter int unsigned DW = 64
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          sgn,
    input  logic [1:0]    sz,
    output logic [DW-1:0] y
);
    localparam int unsigned HALF = DW / 2;

    logic [1:0][DW-1:0] srcs;
    logic [1:0][DW-1:0] res;

    assign srcs = {b, a};

    for (genvar k = 0; k < 2; k++) begin : g_src
        localparam int S = 16 << k;
        localparam int N = S / 2;
        localparam int L = DW / S;
        for (genvar o = 0; o < 2; o++) begin : g_opnd
            for (genvar j = 0; j < L; j++) begin : g_lane
                logic [S-1:0] x;
                logic [N-1:0] nv;
                assign x = srcs[o][j*S +: S];
                always_comb begin
                    if (sgn) begin
                        if ((x[S-1:N-1] == '0) || (x[S-1:N-1] == '1)) nv = x[N-1:0];
                        else nv = x[S-1] ? {1'b1, {(N-1){1'b0}}} : {1'b0, {(N-1){1'b1}}};
                    end else begin
                        nv = (|x[S-1:N]) ? '1 : x[N-1:0];
                    end
                end
                assign res[k][o*HALF + j*N +: N] = nv;
            end
        end
    end

    assign y = (sz == 2'd0) ? '0 : (sz[1] ? res[1] : res[0]);
endmodule

// File: rtl/simd_alu.sv
module simd_alu
    import simd_pkg::*;
#(
    parameter int unsigned DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    input  logic [3:0]    opcode,
    input  logic [1:0]    lane_sz,
    input  logic          is_signed,
    output logic [DW-1:0] result
);
    typedef struct packed {
        logic [DW-1:0] data;
    } alu_state_t;

    simd_op_e      op;
    logic [DW-1:0] as_y;
    logic [DW-1:0] sh_y;
    logic [DW-1:0] cmp_y;
    logic [DW-1:0] mul_y;
    logic [DW-1:0] madd_y;
    logic [DW-1:0] pack_y;
    logic          is_sub;
    logic          is_sat;
    alu_state_t    st_d;
    alu_state_t    st_q;

    assign op     = simd_op_e'(opcode);
    assign is_sub = (op == OP_SUB) || (op == OP_SUBS);
    assign is_sat = (op == OP_ADDS) || (op == OP_SUBS);

    simd_addsub #(.DW(DW)) u_addsub (
        .a(op_a), .b(op_b), .sub(is_sub), .sat(is_sat),
        .sgn(is_signed), .sz(lane_sz), .y(as_y)
    );

    simd_lanewise #(.DW(DW)) u_lanewise (
        .a(op_a), .b(op_b), .op(op), .sgn(is_signed), .sz(lane_sz),
        .sh_y(sh_y), .cmp_y(cmp_y)
    );

    simd_mul #(.DW(DW)) u_mul (
        .a(op_a), .b(op_b), .sgn(is_signed), .mul_y(mul_y), .madd_y(madd_y)
    );

    simd_pack #(.DW(DW)) u_pack (
        .a(op_a), .b(op_b), .sgn(is_signed), .sz(lane_sz), .y(pack_y)
    );

    always_comb begin
        st_d = st_q;
        case (op)
            OP_ADD, OP_ADDS, OP_SUB, OP_SUBS: st_d.data = as_y;
            OP_AND:                           st_d.data = op_a & op_b;
            OP_ANDN:                          st_d.data = ~op_a & op_b;
            OP_OR:                            st_d.data = op_a | op_b;
            OP_XOR:                           st_d.data = op_a ^ op_b;
            OP_SLL, OP_SRL, OP_SRA:           st_d.data = sh_y;
            OP_CMPEQ, OP_CMPGT:               st_d.data = cmp_y;
            OP_MUL:                           st_d.data = mul_y;
            OP_MADD:                          st_d.data = madd_y;
            default:                          st_d.data = pack_y;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result = st_q.data;
endmodule

// File: rtl/simd_alu_chk.sv
module simd_alu_chk
    import simd_pkg::*;
#(
    parameter int unsigned DW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic [DW-1:0] op_a,
    input logic [DW-1:0] op_b,
    input logic [3:0]    opcode,
    input logic [1:0]    lane_sz,
    input logic          is_signed,
    input logic [DW-1:0] result
);
    function automatic logic bytes_are_masks(logic [DW-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < DW / 8; i++) begin
            if (v[i*8 +: 8] != 8'h00 && v[i*8 +: 8] != 8'hFF) ok = 1'b0;
        end
        return ok;
    endfunction

    // R2
    add_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OP_ADD && op_b == '0) |=> (result == $past(op_a)));

    // R4
    usat_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OP_ADDS && !is_signed && op_a == '1) |=> (result == '1));

    // R4
    usat_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OP_SUBS && !is_signed && op_a == '0) |=> (result == '0));

    // R5
    xor_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OP_XOR && op_a == op_b) |=> (result == '0));

    // R7
    wide_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((opcode == OP_SLL || opcode == OP_SRL) && op_b[7:0] >= 8'd32) |=> (result == '0));

    // R8
    eq_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OP_CMPEQ && op_a == op_b) |=> (result == '1));

    // R9
    cmp_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((opcode == OP_CMPEQ || opcode == OP_CMPGT) && lane_sz == 2'd0) |=> bytes_are_masks(result));

    // R12
    pack_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OP_PACK && lane_sz == 2'd0) |=> (result == '0));
endmodule

bind simd_alu simd_alu_chk #(.DW(DW)) u_chk (.*);

// File: tb/tb_simd_alu.sv
`timescale 1ns/1ps
module tb_simd_alu;
    localparam real HALF_PER = 2.5;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] op_a;
    logic [63:0] op_b;
    logic [3:0]  opcode;
    logic [1:0]  lane_sz;
    logic        is_signed;
    logic [63:0] result;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(HALF_PER) clk = ~clk;

    simd_alu dut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .opcode(opcode),
        .lane_sz(lane_sz), .is_signed(is_signed), .result(result)
    );

    function automatic longint sx(longint u, int w);
        return u[w-1] ? u - (longint'(1) << w) : u;
    endfunction

    function automatic longint clamp(longint v, longint lo, longint hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    function automatic logic [63:0] model(logic [63:0] a, logic [63:0] b, logic [3:0] op,
                                          logic [1:0] sz, logic sg);
        int w, cnt;
        logic [63:0] m, r;
        longint ua, ub, sa, sb, v, lo, hi;
        w   = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        cnt = int'(b[7:0]);
        r   = '0;
        case (op)
            4'd4: return a & b;
            4'd5: return ~a & b;
            4'd6: return a | b;
            4'd7: return a ^ b;
            4'd13, 4'd14: begin
                longint p [4];
                for (int i = 0; i < 4; i++) begin
                    ua = longint'((a >> (i*16)) & 64'hFFFF);
                    ub = longint'((b >> (i*16)) & 64'hFFFF);
                    p[i] = sg ? sx(ua, 16) * sx(ub, 16) : ua * ub;
                end
                if (op == 4'd13) begin
                    for (int i = 0; i < 4; i++) r |= (64'(p[i]) & 64'hFFFF) << (i*16);
                end else begin
                    for (int i = 0; i < 2; i++)
                        r |= (64'(p[2*i] + p[2*i+1]) & 64'hFFFF_FFFF) << (i*32);
                end
                return r;
            end
            4'd15: begin
                int nw;
                logic [63:0] nm;
                if (sz == 2'd0) return '0;
                nw = w / 2;
                nm = (64'd1 << nw) - 1;
                m  = (64'd1 << w) - 1;
                lo = sg ? -(longint'(1) << (nw-1)) : 0;
                hi = sg ? (longint'(1) << (nw-1)) - 1 : (longint'(1) << nw) - 1;
                for (int i = 0; i < 64 / w; i++) begin
                    ua = longint'((a >> (i*w)) & m);
                    ub = longint'((b >> (i*w)) & m);
                    v = clamp(sg ? sx(ua, w) : ua, lo, hi);
                    r |= (64'(v) & nm) << (i*nw);
                    v = clamp(sg ? sx(ub, w) : ub, lo, hi);
                    r |= (64'(v) & nm) << (32 + i*nw);
                end
                return r;
            end
            default: ;
        endcase
        m = (64'd1 << w) - 1;
        for (int i = 0; i < 64 / w; i++) begin
            ua = longint'((a >> (i*w)) & m);
            ub = longint'((b >> (i*w)) & m);
            sa = sx(ua, w);
            sb = sx(ub, w);
            lo = sg ? -(longint'(1) << (w-1)) : 0;
            hi = sg ? (longint'(1) << (w-1)) - 1 : (longint'(1) << w) - 1;
            case (op)
                4'd0:  v = ua + ub;
                4'd2:  v = ua - ub;
                4'd1:  v = clamp(sg ? sa + sb : ua + ub, lo, hi);
                4'd3:  v = clamp(sg ? sa - sb : ua - ub, lo, hi);
                4'd8:  v = (cnt >= w) ? 0 : ua << cnt;
                4'd9:  v = (cnt >= w) ? 0 : ua >> cnt;
                4'd10: v = (cnt >= w) ? ((sa < 0) ? -1 : 0) : (sa >>> cnt);
                4'd11: v = (ua == ub) ? -1 : 0;
                default: v = (sg ? (sa > sb) : (ua > ub)) ? -1 : 0;
            endcase
            r |= (64'(v) & m) << (i*w);
        end
        return r;
    endfunction

    function automatic string tag_of(logic [3:0] op, logic sg);
        case (op)
            4'd0, 4'd2:           return "R2";
            4'd1, 4'd3:           return sg ? "R3" : "R4";
            4'd4, 4'd5, 4'd6, 4'd7: return "R5";
            4'd8, 4'd9, 4'd10:    return "R6";
            4'd11:                return "R8";
            4'd12:                return "R9";
            4'd13:                return "R10";
            4'd14:                return "R11";
            default:              return "R12";
        endcase
    endfunction

    task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: op=%0d sz=%0d sgn=%0b got=%h exp=%h",
                     tag, opcode, lane_sz, is_signed, got, exp);
        end
    endtask

    // drive at a falling edge, capture at the next rising edge, sample at the falling edge after
    task automatic run(logic [63:0] a, logic [63:0] b, logic [3:0] op, logic [1:0] sz,
                       logic sg, string tag);
        logic [63:0] exp;
        op_a = a; op_b = b; opcode = op; lane_sz = sz; is_signed = sg;
        exp = model(a, b, op, sz, sg);
        @(negedge clk);
        check(tag, result, exp);
    endtask

    function automatic logic [63:0] pick_word();
        case ($urandom % 8)
            0: return '1;
            1: return '0;
            2: return 64'h8080_8080_8080_8080;
            3: return 64'h7F7F_7F7F_7F7F_7F7F;
            4: return 64'h8000_7FFF_0001_FFFF;
            default: return {$urandom, $urandom};
        endcase
    endfunction

    initial begin
        #(HALF_PER * 2 * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: run did not complete");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0; op_a = '0; op_b = '0; opcode = '0; lane_sz = '0; is_signed = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", result, 64'd0);
        op_a = '1; op_b = 64'h0123_4567_89AB_CDEF; opcode = 4'd6;
        @(negedge clk);
        check("R1", result, 64'd0);
        rst_n = 1'b1;

        // R2: per-lane wrap with no carry between lanes, at each lane size
        run('1, 64'h0101_0101_0101_0101, 4'd0, 2'd0, 1'b0, "R2");
        check("R2", result, 64'd0);
        run('1, 64'h0101_0101_0101_0101, 4'd0, 2'd1, 1'b0, "R2");
        check("R2", result, 64'h0100_0100_0100_0100);
        run(64'd0, 64'h0001_0000_0001, 4'd2, 2'd2, 1'b0, "R2");
        run(64'd0, 64'h0001_0000_0001, 4'd2, 2'd3, 1'b0, "R2");
        // R3: signed clamping
        run(64'h7F7F_7F7F_7F7F_7F7F, 64'h0101_0101_0101_0101, 4'd1, 2'd0, 1'b1, "R3");
        check("R3", result, 64'h7F7F_7F7F_7F7F_7F7F);
        run(64'h8000_0000_8000_0000, 64'h0000_0001_0000_0001, 4'd3, 2'd2, 1'b1, "R3");
        // R4: unsigned clamping
        run(64'hFFFF_0000_FFFF_0000, 64'h0001_0001_0001_0001, 4'd1, 2'd1, 1'b0, "R4");
        run(64'h0000_0005_0000_0005, 64'h0000_0006_0000_0001, 4'd3, 2'd2, 1'b0, "R4");
        // R5
        run(64'hF0F0_1234_0000_FFFF, 64'hFF00_FF00_FF00_FF00, 4'd5, 2'd1, 1'b0, "R5");
        // R6 / R7 shifts
        run(64'h8123_4567_F000_0001, 64'd4, 4'd10, 2'd1, 1'b0, "R6");
        run(64'h8000_0000_7000_0000, 64'd40, 4'd10, 2'd2, 1'b0, "R7");
        check("R7", result, 64'hFFFF_FFFF_0000_0000);
        run('1, 64'd8, 4'd9, 2'd0, 1'b0, "R7");
        check("R7", result, 64'd0);
        run('1, 64'd16, 4'd8, 2'd1, 1'b0, "R7");
        // R8 / R9 compares
        run(64'h0102_0304_0506_0708, 64'h0102_0000_0506_0000, 4'd11, 2'd0, 1'b0, "R8");
        run(64'h8080_8080_8080_8080, 64'h0101_0101_0101_0101, 4'd12, 2'd0, 1'b1, "R9");
        check("R9", result, 64'd0);
        run(64'h8080_8080_8080_8080, 64'h0101_0101_0101_0101, 4'd12, 2'd0, 1'b0, "R9");
        check("R9", result, '1);
        // R10 / R11 multiplies
        run('1, '1, 4'd13, 2'd0, 1'b1, "R10");
        check("R10", result, 64'h0001_0001_0001_0001);
        run('1, '1, 4'd14, 2'd0, 1'b1, "R11");
        check("R11", result, 64'h0000_0002_0000_0002);
        run('1, '1, 4'd14, 2'd2, 1'b0, "R11");
        check("R11", result, 64'hFFFC_0002_FFFC_0002);
        // R12 packs
        run(64'h0100_FF00_007F_FF80, 64'h7FFF_8000_0001_FFFF, 4'd15, 2'd1, 1'b1, "R12");
        check("R12", result, 64'h7F80_01FF_7F80_7F80);
        run(64'h0100_FF00_007F_FF80, 64'h7FFF_8000_0001_FFFF, 4'd15, 2'd1, 1'b0, "R12");
        run(64'h0001_0000_FFFF_8000, 64'h0000_1234_7FFF_FFFF, 4'd15, 2'd2, 1'b1, "R12");
        run('1, '1, 4'd15, 2'd0, 1'b1, "R12");
        check("R12", result, 64'd0);

        for (int n = 0; n < 1500; n++) begin
            logic [63:0] a, b;
            logic [3:0]  op;
            logic        sg;
            a  = pick_word();
            b  = pick_word();
            op = 4'($urandom % 16);
            sg = 1'($urandom % 2);
            if (op >= 4'd8 && op <= 4'd10) b[7:0] = 8'($urandom % 40);
            if (op == 4'd11 && ($urandom % 4) == 0) b = a;
            run(a, b, op, 2'($urandom % 4), sg, tag_of(op, sg));
        end

        // R1: reset clears a live result
        run('1, '1, 4'd4, 2'd0, 1'b0, "R5");
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", result, 64'd0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule